// File: doc/BRIEF.md
# Four-Ratio Multimodulus Clock Prescaler

This block divides one input clock by 32, 33, 47 or 48. Two mode inputs choose the ratio. A band-select input picks the low pair (32/33) or the high pair (47/48). A modulus-control input picks the ratio within the pair. In both bands a low modulus-control value selects the larger ratio.

Inside the block, a dual-modulus core counts either two or three input cycles per core period. Its end-of-period strobe drives a cascade of four toggle stages, so one output period always contains sixteen core periods. The control logic derives the core's length-select from two things: whether the cascade has reached its all-ones terminal state, and the stored mode. In the high band the length-select is inverted before it reaches the core.

The high ratios therefore need no extra state. One core period per output period differs from the other fifteen. The first flip-flop of the core holds at zero during every two-cycle core period.

The mode inputs are stored only at the clock edge that ends an output period, and also on every clock edge while reset is high. A ratio change therefore always begins on a period boundary. The block drives two outputs:
- a one-cycle pulse that marks the end of each period;
- a square-ish waveform taken from the last toggle stage.

Top module: `mmod_prescaler`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `divPulse` and `divOut` are 0. After `rst` falls, the first `divPulse` is high exactly N cycles after the first rising edge with `rst` low. N is the ratio selected by the mode inputs at the last reset edge.
- R2: With `bandSel`=0 and `modCtl`=1, consecutive `divPulse` pulses are 32 cycles apart. All sixteen core periods are two cycles long.
- R3: With `bandSel`=0 and `modCtl`=0, the period is 33 cycles. Fifteen core periods last two cycles and the final one lasts three.
- R4: With `bandSel`=1 and `modCtl`=0, the period is 48 cycles. Every core period lasts three cycles.
- R5: With `bandSel`=1 and `modCtl`=1, the period is 47 cycles. Fifteen core periods last three cycles and the final one lasts two.
- R6: `bandSel` and `modCtl` are sampled only on the rising edge where `divPulse` goes high, and on reset edges. The sampled values set the length of the following period. Changes between those edges do not alter the running period.
- R7: `divPulse` is high for exactly one cycle per output period, and never for two cycles in a row.
- R8: `divOut` is low for the first eight core periods of an output period and high for the last eight. It falls on the edge where `divPulse` rises. Per period it is high for 16, 17, 24 or 23 cycles for ratios 32, 33, 48 and 47 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; mode inputs are also captured while it is high |
| bandSel | input | 1 | 0 = low band (32/33), 1 = high band (48/47) |
| modCtl | input | 1 | 0 = larger ratio of the band, 1 = smaller ratio |
| divOut | output | 1 | Square-ish divided clock, high during the last eight core periods |
| divPulse | output | 1 | One-cycle pulse after the edge that ends each output period |

## Verification
The assertions assume that `bandSel` and `modCtl` are settled at every rising edge. They do not assume that the inputs stay constant within a period: any mid-period change is allowed, and only the value at the boundary edge counts.

The stimulus drives every input change at the falling clock edge. It places the chosen next-period mode one cycle before the expected boundary. It scatters random mode toggles through the rest of the period so that the sampling rule of R6 is exercised against all four ratios.

// File: rtl/mmpresc_pkg.sv
package mmpresc_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic mc;         // 1: core period of two cycles, 0: three cycles
    logic periodEnd;  // this cycle ends an output period
  } ctrlStrobe_t;

  // stored mode word
  typedef struct packed {
    logic bandHi;
    logic modSmall;
  } modeWord_t;

endpackage

// File: rtl/presc_core23.sv
module presc_core23 (
  input  logic clk,
  input  logic rst,
  input  logic mc,
  output logic coreTick,
  output logic firstStage
);

  logic stageA;  // extra-cycle flop, idle during two-cycle periods
  logic stageB;  // phase flop

  always_ff @(posedge clk) begin
    if (rst) begin
      stageA <= 1'b0;
      stageB <= 1'b0;
    end else if (stageA) begin
      stageA <= 1'b0;
      stageB <= 1'b0;
    end else if (!stageB) begin
      stageB <= 1'b1;
    end else if (mc) begin
      stageB <= 1'b0;
    end else begin
      stageA <= 1'b1;
    end
  end

  assign coreTick   = stageB & (stageA | mc);
  assign firstStage = stageA;

  // R3
  ext_cycle_shape_chk: assert property (@(posedge clk) disable iff (rst)
    stageA |-> stageB);

  // R5
  ext_cycle_single_chk: assert property (@(posedge clk) disable iff (rst)
    stageA |=> (!stageA && !stageB));

endmodule

// File: rtl/presc_datapath.sv
module presc_datapath
  import mmpresc_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strb,
  output logic        coreTick,
  output logic        chainTerm,
  output logic        firstStage,
  output logic        divOut,
  output logic        divPulse
);

  logic [STAGES-1:0] chainQ;
  logic [STAGES:0]   chainEn;
  logic              pulseQ;

  presc_core23 core_i (
    .clk        (clk),
    .rst        (rst),
    .mc         (strb.mc),
    .coreTick   (coreTick),
    .firstStage (firstStage)
  );

  assign chainEn[0] = coreTick;

  for (genvar i = 0; i < STAGES; i++) begin : g_toggle
    always_ff @(posedge clk) begin
      if (rst) chainQ[i] <= 1'b0;
      else     chainQ[i] <= chainQ[i] ^ chainEn[i];
    end
    assign chainEn[i+1] = chainEn[i] & chainQ[i];
  end

  assign chainTerm = &chainQ;

  always_ff @(posedge clk) begin
    if (rst) pulseQ <= 1'b0;
    else     pulseQ <= strb.periodEnd;
  end

  assign divPulse = pulseQ;
  assign divOut   = chainQ[STAGES-1];

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R8
  out_falls_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(divPulse) |-> !divOut);

endmodule

// File: rtl/presc_control.sv
module presc_control
  import mmpresc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bandSel,
  input  logic        modCtl,
  input  logic        coreTick,
  input  logic        chainTerm,
  output ctrlStrobe_t strb,
  output modeWord_t   modeQ
);

  logic extReq;
  logic mcRaw;
  logic endNow;

  assign endNow = coreTick & chainTerm;

  always_ff @(posedge clk) begin
    if (rst || endNow) begin
      modeQ.bandHi   <= bandSel;
      modeQ.modSmall <= modCtl;
    end
  end

  // the odd core period is requested only in the terminal chain state
  assign extReq = chainTerm & ~(modeQ.bandHi ^ modeQ.modSmall);
  assign mcRaw  = ~extReq;

  assign strb.mc        = modeQ.bandHi ? ~mcRaw : mcRaw;
  assign strb.periodEnd = endNow;

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !endNow |=> $stable(modeQ));

endmodule

// File: rtl/mmod_prescaler.sv
module mmod_prescaler
  import mmpresc_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bandSel,
  input  logic modCtl,
  output logic divOut,
  output logic divPulse
);

  localparam int MinRatio = (1 << STAGES) * 2;
  localparam int MaxRatio = (1 << STAGES) * 3;
  localparam int GapW     = $clog2(MaxRatio + 1);

  ctrlStrobe_t strb;
  modeWord_t   modeQ;
  logic        coreTick;
  logic        chainTerm;
  logic        firstStage;
  logic [GapW-1:0] gapCnt;

  presc_control ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .bandSel   (bandSel),
    .modCtl    (modCtl),
    .coreTick  (coreTick),
    .chainTerm (chainTerm),
    .strb      (strb),
    .modeQ     (modeQ)
  );

  presc_datapath #(.STAGES(STAGES)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .coreTick   (coreTick),
    .chainTerm  (chainTerm),
    .firstStage (firstStage),
    .divOut     (divOut),
    .divPulse   (divPulse)
  );

  // cycle counter for the period-bound check
  always_ff @(posedge clk) begin
    if (rst)                gapCnt <= '0;
    else if (divPulse)      gapCnt <= GapW'(1);
    else if (gapCnt < GapW'(MaxRatio)) gapCnt <= gapCnt + 1'b1;
  end

  // R2
  first_stage_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!modeQ.bandHi && modeQ.modSmall) |-> !firstStage);

  // R1
  period_bound_chk: assert property (@(posedge clk) disable iff (rst)
    divPulse |-> (gapCnt >= GapW'(MinRatio) && gapCnt <= GapW'(MaxRatio)));

endmodule

// File: tb/mmod_prescaler_tb_top.sv
module mmod_prescaler_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bandSel = 1'b0;
  logic modCtl = 1'b1;
  wire  divOut;
  wire  divPulse;

  int checks = 0;
  int fails = 0;
  bit timedOut = 0;

  always #4 clk = ~clk;

  mmod_prescaler dut_i (
    .clk      (clk),
    .rst      (rst),
    .bandSel  (bandSel),
    .modCtl   (modCtl),
    .divOut   (divOut),
    .divPulse (divPulse)
  );

  function automatic int ratioOf(bit s, bit m);
    return s ? (m ? 47 : 48) : (m ? 32 : 33);
  endfunction

  function automatic int highOf(bit s, bit m);
    return s ? (m ? 23 : 24) : (m ? 16 : 17);
  endfunction

  function automatic string reqOf(bit s, bit m);
    if (!s) return m ? "R2" : "R3";
    return m ? "R5" : "R4";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // directed mode sequence, {bandSel, modCtl}
  function automatic bit [1:0] directed(int idx);
    case (idx % 8)
      0: return 2'b01;
      1: return 2'b00;
      2: return 2'b00;
      3: return 2'b10;
      4: return 2'b10;
      5: return 2'b11;
      6: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic runPeriods(int nPer, bit afterReset, bit noise);
    int p = 0;
    int cyc = 0;
    int hi = 0;
    bit prevP = 0;
    bit noisy = 0;
    bit sNow = bandSel;
    bit mNow = modCtl;
    int expN = ratioOf(bandSel, modCtl);
    int expH = highOf(bandSel, modCtl);
    while (p < nPer) begin
      @(negedge clk);
      cyc++;
      if (divOut) hi++;
      if (prevP) check(divPulse == 1'b0, "R7", int'(divPulse), 0);
      prevP = divPulse;
      if (divPulse) begin
        check(cyc == expN,
              (p == 0 && afterReset) ? "R1" : (noisy ? "R6" : reqOf(sNow, mNow)),
              cyc, expN);
        check(hi == expH, "R8", hi, expH);
        sNow = bandSel;
        mNow = modCtl;
        expN = ratioOf(sNow, mNow);
        expH = highOf(sNow, mNow);
        cyc = 0;
        hi = 0;
        noisy = 0;
        p++;
      end else if (cyc > 60) begin
        check(1'b0, "R7 watchdog", cyc, expN);
        timedOut = 1;
        return;
      end
      if (cyc == expN - 1) begin
        bit [1:0] nx;
        if (noise) nx = 2'($urandom_range(0, 3));
        else       nx = directed(p + 1);
        bandSel = nx[1];
        modCtl  = nx[0];
      end else if (noise && cyc < expN - 1 && $urandom_range(0, 3) == 0) begin
        bandSel = 1'($urandom_range(0, 1));
        modCtl  = 1'($urandom_range(0, 1));
        if ({bandSel, modCtl} != {sNow, mNow}) noisy = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    rst = 1'b1;
    bandSel = 1'b0;
    modCtl = 1'b1;
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R1", int'(divPulse), 0);
    check(divOut == 1'b0, "R1", int'(divOut), 0);
    rst = 1'b0;
    runPeriods(12, 1, 0);
    if (!timedOut) runPeriods(50, 0, 1);
    if (!timedOut) begin
      repeat (13) @(negedge clk);
      rst = 1'b1;
      bandSel = 1'b1;
      modCtl = 1'b1;
      repeat (2) @(negedge clk);
      check(divPulse == 1'b0, "R1", int'(divPulse), 0);
      check(divOut == 1'b0, "R1", int'(divOut), 0);
      rst = 1'b0;
      runPeriods(6, 1, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R7 watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule